// File: doc/BRIEF.md
# GPIO Port with Peripheral Pad Override

This block is one parallel I/O port of configurable width sitting on a simple register bus. Software sees three registers. The direction register decides which pins drive. The output latch holds the value that driving pins put out. The pin register shows the synchronized levels at the pads. Writing either the latch or the pin address loads the latch. Reading the pin address returns the pads, while reading the latch address returns the stored value.

Each bit also has an ownership multiplexer in front of its pad. While a peripheral is both enabled and actively driving that bit, it takes the pad's output data and output enable. The port can still read the pin level through the pin register. A parameter mask marks the implemented bits. The remaining bits read as zero, ignore writes and never drive their pads.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 1 on every implemented bit and 0 elsewhere, the latch reads all zeros, and every pad output enable is 0.
- R2: With no override on a bit, its pad output enable is the inverse of its direction bit (0 = output, 1 = input), and its pad output is its latch bit. Both pad signals are registered and follow their sources one clock later.
- R3: A read of the latch address (1) returns the latch contents, not the pad levels.
- R4: A read of the pin address (2) returns the pad inputs after a two-flop synchronizer. This holds for input pins and output pins alike.
- R5: A write to the latch address (1) or to the pin address (2) loads the write data into the latch. A write to the direction address (0) loads the direction register.
- R6: When a bit's peripheral enable and drive-active are both 1, the pad output enable for that bit is 1 and the pad output is the peripheral data. The pin address still returns that pad's input level.
- R7: A peripheral that is enabled but not driving, or driving but not enabled, leaves the bit under port control as in R2.
- R8: Unimplemented bits (mask bit 0) read as 0 at every address, ignore writes, and hold pad output and pad output enable at 0 whatever the peripheral does.
- R9: Read data is registered and appears one cycle after the address is presented. The reserved address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 direction, 1 latch, 2 pins, 3 reserved |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pad_out | output | WIDTH | Pad output data |
| pad_oe | output | WIDTH | Pad output enable, 1 = drive |
| pad_in | input | WIDTH | Pad input levels |
| per_en | input | WIDTH | Per-bit peripheral enable |
| per_act | input | WIDTH | Per-bit peripheral actively driving |
| per_dout | input | WIDTH | Per-bit peripheral output data |

## Verification
Every 8-bit value is written to and read back from the direction register and the latch. These sweeps separate masked bits from stored bits and show whether the pin address is aliased onto the latch. A separate sweep of all 256 pad patterns, taken with the latch held at a different value, tells a pin read apart from a latch read. Arithmetic patterns over peripheral enable, drive-active and data, mixed with changing direction and latch values, cover all four override combinations on every bit. They show whether ownership requires both control signals and whether unimplemented bits stay quiet.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_DIR = 2'd0,
    REG_LAT = 2'd1,
    REG_PIN = 2'd2,
    REG_RSV = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  assert_sync_first_R4: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> stg[0] == $past(din));

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
    assert_sync_chain_R4: assert property (@(posedge clk) disable iff (rst)
      past_ok |-> stg[s] == $past(stg[s-1]));
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  lat_q
);
  reg_sel_e sel;
  logic [WIDTH-1:0] rd_next;
  logic past_ok;

  assign sel = reg_sel_e'(addr);

  always_comb begin
    case (sel)
      REG_DIR: rd_next = dir_q;
      REG_LAT: rd_next = lat_q;
      REG_PIN: rd_next = pin_sync & IMPL_MASK;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= IMPL_MASK;
      lat_q   <= '0;
      rdata   <= '0;
      past_ok <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      rdata   <= rd_next;
      if (we) begin
        case (sel)
          REG_DIR:          dir_q <= wdata & IMPL_MASK;
          REG_LAT, REG_PIN: lat_q <= wdata & IMPL_MASK;
          default: ;
        endcase
      end
    end
  end

  assert_latch_write_R5: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(we) && ($past(addr) == REG_LAT || $past(addr) == REG_PIN)
      |-> lat_q == ($past(wdata) & IMPL_MASK));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(we) |-> $stable(lat_q) && $stable(dir_q));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(addr) == REG_RSV |-> rdata == '0);
endmodule

// File: rtl/gpio_padmux.sv
module gpio_padmux #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] lat_q,
  input  logic [WIDTH-1:0] per_en,
  input  logic [WIDTH-1:0] per_act,
  input  logic [WIDTH-1:0] per_dout,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe
);
  logic [WIDTH-1:0] nxt_out, nxt_oe, own;
  logic past_ok;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      assign own[i]     = per_en[i] & per_act[i];
      assign nxt_out[i] = own[i] ? per_dout[i] : lat_q[i];
      assign nxt_oe[i]  = own[i] | ~dir_q[i];
    end else begin : g_absent
      assign own[i]     = 1'b0;
      assign nxt_out[i] = 1'b0;
      assign nxt_oe[i]  = 1'b0;
    end

    assert_override_R6: assert property (@(posedge clk) disable iff (rst)
      past_ok && IMPL_MASK[i] && $past(per_en[i] && per_act[i])
        |-> pad_oe[i] && pad_out[i] == $past(per_dout[i]));

    assert_port_owns_R7: assert property (@(posedge clk) disable iff (rst)
      past_ok && IMPL_MASK[i] && !$past(per_en[i] && per_act[i])
        |-> pad_oe[i] == !$past(dir_q[i]) && pad_out[i] == $past(lat_q[i]));

    assert_absent_quiet_R8: assert property (@(posedge clk) disable iff (rst)
      !IMPL_MASK[i] |-> !pad_oe[i] && !pad_out[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      past_ok <= 1'b0;
    end else begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
      past_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] IMPL_MASK = 8'hBF,
  parameter int               SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic [WIDTH-1:0]  pad_in,
  input  logic [WIDTH-1:0]  per_en,
  input  logic [WIDTH-1:0]  per_act,
  input  logic [WIDTH-1:0]  per_dout
);
  logic [WIDTH-1:0] pin_sync, dir_q, lat_q;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .din(pad_in), .dout(pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .pin_sync(pin_sync), .rdata(bus_rdata), .dir_q(dir_q), .lat_q(lat_q)
  );

  gpio_padmux #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_padmux (
    .clk(clk), .rst(rst), .dir_q(dir_q), .lat_q(lat_q),
    .per_en(per_en), .per_act(per_act), .per_dout(per_dout),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assert_rdata_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~IMPL_MASK) == '0);
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
  localparam int         W    = 8;
  localparam logic [7:0] MASK = 8'hBF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [W-1:0] bus_wdata = '0, pad_in = '0, per_en = '0, per_act = '0, per_dout = '0;
  logic [W-1:0] bus_rdata, pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  gpio_port #(.WIDTH(W), .IMPL_MASK(MASK)) i_gpio_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_in(pad_in), .per_en(per_en), .per_act(per_act),
    .per_dout(per_dout)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [W-1:0] exp_oe(input logic [W-1:0] dir, en, act);
    return ((en & act) | ~dir) & MASK;
  endfunction

  function automatic logic [W-1:0] exp_out(input logic [W-1:0] lat, en, act, dout);
    return (((en & act) & dout) | (~(en & act) & lat)) & MASK;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rd, dir, lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    bus_read(2'd0, rd); check("R1 dir reset", rd, MASK);
    bus_read(2'd1, rd); check("R1 latch reset", rd, 8'h00);
    check("R1 oe reset", pad_oe, 8'h00);

    // R5 R8 direction sweep
    for (int v = 0; v < 256; v++) begin
      bus_write(2'd0, 8'(v));
      bus_read(2'd0, rd);
      check("R5 R8 dir readback", rd, 8'(v) & MASK);
    end

    // R2 R3 R5 latch sweep through both write addresses, all pins outputs
    bus_write(2'd0, 8'h00);
    pad_in = 8'h5A;
    for (int v = 0; v < 256; v++) begin
      bus_write((v % 2 == 0) ? 2'd1 : 2'd2, 8'(v));
      bus_read(2'd1, rd);
      check("R3 R5 latch readback", rd, 8'(v) & MASK);
      check("R2 pad_out follows latch", pad_out, 8'(v) & MASK);
      check("R2 pad_oe output dir", pad_oe, MASK);
    end

    // R4 pin sweep with latch holding a different value
    bus_write(2'd1, 8'hC3);
    for (int v = 0; v < 256; v++) begin
      pad_in = 8'(v);
      tick(); tick();
      bus_read(2'd2, rd);
      check("R4 pin read", rd, 8'(v) & MASK);
    end

    // R4 synchronizer depth: change not visible one cycle early
    pad_in = 8'h00; tick(); tick(); tick();
    pad_in = 8'hFF; tick();
    bus_read(2'd2, rd);
    check("R4 two-flop delay", rd, 8'h00);

    // R9 reserved address and one-cycle latency
    bus_read(2'd3, rd); check("R9 reserved reads zero", rd, 8'h00);
    bus_addr = 2'd1; #1;
    check("R9 rdata still previous before edge", bus_rdata, 8'h00);
    tick();
    check("R9 rdata after one edge", bus_rdata, 8'hC3 & MASK);

    // R6 R7 R8 override sweep
    for (int k = 0; k < 512; k++) begin
      if (k % 64 == 0) begin
        dir = 8'(k * 29 + 7);
        lat = 8'(k * 13 + 200);
        bus_write(2'd0, dir);
        bus_write(2'd1, lat);
      end
      per_en   = 8'(k * 37 + 1);
      per_act  = 8'(k * 91 + 3);
      per_dout = 8'(k * 53) ^ 8'h5C;
      pad_in   = 8'(k * 17);
      tick();
      check("R6 R7 R8 pad_oe", pad_oe, exp_oe(dir & MASK, per_en, per_act));
      check("R6 R7 R8 pad_out", pad_out, exp_out(lat & MASK, per_en, per_act, per_dout));
    end

    // R6 pins readable under full override
    per_en = 8'hFF; per_act = 8'hFF; per_dout = 8'h0F; pad_in = 8'hA5;
    tick(); tick();
    bus_read(2'd2, rd);
    check("R6 pin read under override", rd, 8'hA5 & MASK);
    check("R6 pad_out peripheral", pad_out, 8'h0F & MASK);

    // R7 enabled but idle, idle but not enabled
    bus_write(2'd0, 8'hF0); bus_write(2'd1, 8'h3C);
    per_en = 8'hFF; per_act = 8'h00; tick();
    check("R7 enabled not driving oe", pad_oe, 8'h0F);
    check("R7 enabled not driving out", pad_out, 8'h3C);
    per_en = 8'h00; per_act = 8'hFF; tick();
    check("R7 driving not enabled oe", pad_oe, 8'h0F);

    // R8 unimplemented bit writes ignored
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, rd); check("R8 latch masked", rd, MASK);
    per_en = 8'hFF; per_act = 8'hFF; per_dout = 8'hFF; tick();
    check("R8 absent bit never drives", pad_oe & ~MASK, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule